// File: doc/BRIEF.md
# Wall-Switch Override Mode Sequencer

This block decides the operating state of a motion-activated lamp controller. It runs on the 16 kHz system clock. It watches a stream of single-cycle zero-crossing pulses, a decoded three-way mode strap and a validated motion-trigger pulse. From these it reports one of five states: warm-up, quick-install, automatic, forced-on or off.

Turning the wall switch off and on leaves gaps in the zero-crossing stream. Two such gaps close together form an override gesture. Early after power-up a gesture puts the block into a short-timeout quick-install state. Once warm-up has finished, a gesture toggles the lamp between forced-on and automatic. The forced-on state returns to automatic by itself after a long hold. A gap long enough to mean the mains has gone away restarts the whole initialization.

Every time window is a cycle-count parameter, so a bench can scale the timing down. The default values match the 16 kHz clock: 30 ms minimum gap, 3 s loss and gesture windows, 40 s warm-up, 10 s quick-install entry window, 1.3 s quick-install lamp pulse, 32 s quick-install idle and 5 h override.

Top module: `zc_override_seq`

## Requirements
- R1: After reset with the mode strap open, `op_state` reads warm-up (code 0) for WARM_CYC cycles of uninterrupted zero-crossings, then reads automatic (code 2).
- R2: `trig_out` follows `motion_trig` only while `op_state` is automatic. In warm-up, quick-install, forced-on and off, motion pulses are ignored and `trig_out` stays 0.
- R3: `mode_sel` 2'b01 forces state forced-on (code 3) with `lamp_on` high. `mode_sel` 2'b10 forces state off (code 4) with `lamp_on` low. `mode_sel` 2'b00 or 2'b11 selects automatic sequencing.
- R4: A switch-off event is a zero-crossing pulse that arrives after a gap of at least GAP_MIN_CYC cycles and fewer than LOSS_CYC cycles. A gesture is a second such event that comes within GEST_WIN_CYC cycles of the first. A lone event, or two events spaced wider than the window, changes nothing.
- R5: A gesture in automatic sequencing while fewer than QI_WIN_CYC cycles have passed since initialization started moves the block to quick-install (code 1).
- R6: In quick-install, each motion pulse drives `lamp_on` high for QI_PULSE_CYC cycles. After QI_IDLE_CYC cycles with no motion, the block leaves quick-install.
- R7: If quick-install ends before WARM_CYC cycles of initialization have passed, the state reads warm-up until that count completes, and then reads automatic.
- R8: After warm-up, each gesture toggles between forced-on (with `lamp_on` high) and automatic. Gestures made after the quick-install window but before warm-up ends are ignored.
- R9: Forced-on entered by a gesture returns to automatic after OVR_ON_CYC cycles if no further gesture occurs.
- R10: When no zero-crossing pulse has arrived for LOSS_CYC cycles, `restart` pulses high for exactly one cycle. Quick-install and override are cleared, and a fresh warm-up of the full WARM_CYC cycles starts from the first pulse after the mains returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| zc_pulse | input | 1 | One-cycle pulse per debounced mains zero crossing |
| mode_sel | input | 2 | Decoded mode strap: 01 forced on, 10 off, 00/11 open |
| motion_trig | input | 1 | One-cycle pulse per validated motion detection |
| op_state | output | 3 | 0 warm-up, 1 quick-install, 2 automatic, 3 forced-on, 4 off |
| lamp_on | output | 1 | Lamp demand from forced-on or a quick-install pulse |
| trig_out | output | 1 | Motion pulse forwarded only in automatic state |
| restart | output | 1 | One-cycle pulse when mains loss restarts initialization |

## Verification
The assertions assume that `zc_pulse` and `motion_trig` are single-cycle pulses. They also assume that the timing parameters are ordered with the quick-install window shorter than warm-up and the minimum gap shorter than the loss threshold. The stimulus keeps the pulses one cycle wide and spaces zero-crossings three cycles apart while the mains is present, so ordinary half-cycles never count as gaps. Gestures are made by holding the pulse stream off for a set number of cycles that falls between the gap minimum and the loss threshold. Mains loss is modelled by holding the stream off past the loss threshold.

// File: rtl/zc_override_seq.sv
module zc_override_seq #(
  parameter int unsigned GAP_MIN_CYC  = 480,
  parameter int unsigned LOSS_CYC     = 48000,
  parameter int unsigned GEST_WIN_CYC = 48000,
  parameter int unsigned WARM_CYC     = 640000,
  parameter int unsigned QI_WIN_CYC   = 160000,
  parameter int unsigned QI_PULSE_CYC = 20800,
  parameter int unsigned QI_IDLE_CYC  = 512000,
  parameter int unsigned OVR_ON_CYC   = 288000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       zc_pulse,
  input  logic [1:0] mode_sel,
  input  logic       motion_trig,
  output logic [2:0] op_state,
  output logic       lamp_on,
  output logic       trig_out,
  output logic       restart
);

  localparam int GW = $clog2(LOSS_CYC + 1);
  localparam int WW = $clog2(GEST_WIN_CYC);
  localparam int LW = $clog2(WARM_CYC + 1);
  localparam int HW = $clog2(QI_PULSE_CYC + 1);
  localparam int IW = $clog2(QI_IDLE_CYC);
  localparam int OW = $clog2(OVR_ON_CYC);

  localparam logic [GW-1:0] GAP_LOSS  = GW'(LOSS_CYC);
  localparam logic [GW-1:0] GAP_LAST  = GW'(LOSS_CYC - 1);
  localparam logic [GW-1:0] GAP_MIN   = GW'(GAP_MIN_CYC);
  localparam logic [WW-1:0] WIN_LAST  = WW'(GEST_WIN_CYC - 1);
  localparam logic [LW-1:0] LIFE_DONE = LW'(WARM_CYC);
  localparam logic [LW-1:0] LIFE_QI   = LW'(QI_WIN_CYC);
  localparam logic [HW-1:0] HOLD_INIT = HW'(QI_PULSE_CYC);
  localparam logic [IW-1:0] IDLE_LAST = IW'(QI_IDLE_CYC - 1);
  localparam logic [OW-1:0] OVR_LAST  = OW'(OVR_ON_CYC - 1);

  typedef enum logic [2:0] {
    ST_WARMUP = 3'd0, ST_QUICK = 3'd1, ST_AUTO = 3'd2, ST_ON = 3'd3, ST_OFF = 3'd4
  } st_e;

  logic [GW-1:0] gap;
  logic [WW-1:0] win;
  logic [LW-1:0] life;
  logic [HW-1:0] hold;
  logic [IW-1:0] idle;
  logic [OW-1:0] ovr_t;
  logic          pend, qi, ovr, restart_q;
  st_e           st;

  wire lost      = gap == GAP_LOSS;
  wire loss_evt  = !zc_pulse && gap == GAP_LAST;
  wire off_evt   = zc_pulse && gap >= GAP_MIN && !lost;
  wire gesture   = off_evt && pend;
  wire force_on  = mode_sel == 2'b01;
  wire force_off = mode_sel == 2'b10;
  wire open_mode = !force_on && !force_off;
  wire wipe      = lost || loss_evt || !open_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap       <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= loss_evt;
      if (zc_pulse) gap <= '0;
      else if (!lost) gap <= gap + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      win  <= '0;
    end else if (lost || loss_evt) begin
      pend <= 1'b0;
    end else if (off_evt) begin
      pend <= !pend;
      win  <= '0;
    end else if (pend) begin
      if (win == WIN_LAST) pend <= 1'b0;
      else win <= win + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) life <= '0;
    else if (lost || loss_evt) life <= '0;
    else if (life != LIFE_DONE) life <= life + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qi   <= 1'b0;
      hold <= '0;
      idle <= '0;
    end else if (wipe) begin
      qi   <= 1'b0;
      hold <= '0;
    end else if (!qi) begin
      if (gesture && life < LIFE_QI) begin
        qi   <= 1'b1;
        idle <= '0;
        hold <= '0;
      end
    end else if (motion_trig) begin
      hold <= HOLD_INIT;
      idle <= '0;
    end else begin
      if (hold != '0) hold <= hold - 1'b1;
      if (idle == IDLE_LAST) begin
        qi   <= 1'b0;
        hold <= '0;
      end else begin
        idle <= idle + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr   <= 1'b0;
      ovr_t <= '0;
    end else if (wipe) begin
      ovr <= 1'b0;
    end else if (gesture && !qi && life == LIFE_DONE) begin
      ovr   <= !ovr;
      ovr_t <= '0;
    end else if (ovr) begin
      if (ovr_t == OVR_LAST) ovr <= 1'b0;
      else ovr_t <= ovr_t + 1'b1;
    end
  end

  always_comb begin
    if (force_on)             st = ST_ON;
    else if (force_off)       st = ST_OFF;
    else if (qi)              st = ST_QUICK;
    else if (ovr)             st = ST_ON;
    else if (life != LIFE_DONE) st = ST_WARMUP;
    else                      st = ST_AUTO;
  end

  assign op_state = st;
  assign lamp_on  = (st == ST_ON) || (st == ST_QUICK && hold != '0);
  assign trig_out = motion_trig && st == ST_AUTO;
  assign restart  = restart_q;

  assert_loss_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    loss_evt |=> restart && life == '0 && !qi && !ovr);

  assert_quick_entry_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qi) |-> $past(life) < LIFE_QI);

  assert_override_after_warm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(life) == LIFE_DONE);

  assert_hold_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold != '0 |-> qi && hold <= HOLD_INIT);

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({qi, ovr}));

  assert_restart_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);

endmodule

// File: tb/zc_override_seq_tb.sv
`timescale 1ns/1ps
module zc_override_seq_tb;
  localparam int GAP_MIN = 8, LOSS = 60, GWIN = 50, WARM = 400;
  localparam int QIWIN = 120, QIPUL = 10, QIIDLE = 80, OVRON = 300;

  logic clk = 0, rst_n = 0, zc_pulse = 0, motion_trig = 0, ac_on = 1;
  logic [1:0] mode_sel = 2'b00;
  logic [2:0] op_state;
  logic lamp_on, trig_out, restart;
  int checks = 0, fails = 0, zc_phase = 0;

  zc_override_seq #(.GAP_MIN_CYC(GAP_MIN), .LOSS_CYC(LOSS), .GEST_WIN_CYC(GWIN),
    .WARM_CYC(WARM), .QI_WIN_CYC(QIWIN), .QI_PULSE_CYC(QIPUL),
    .QI_IDLE_CYC(QIIDLE), .OVR_ON_CYC(OVRON)) u_dut (
    .clk(clk), .rst_n(rst_n), .zc_pulse(zc_pulse), .mode_sel(mode_sel),
    .motion_trig(motion_trig), .op_state(op_state), .lamp_on(lamp_on),
    .trig_out(trig_out), .restart(restart));

  always #2.5 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // behavioural reference: elapsed-time bookkeeping in integers
  int since_zc = 0, first_evt = -1, boot = 0, qi_quiet = 0, qi_lamp = 0, ovr_age = 0;
  bit in_qi = 0, in_ovr = 0, m_restart = 0;

  function automatic int m_state();
    if (mode_sel == 2'b01) return 3;
    if (mode_sel == 2'b10) return 4;
    if (in_qi) return 1;
    if (in_ovr) return 3;
    return (boot < WARM) ? 0 : 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_zc = 0; first_evt = -1; boot = 0; in_qi = 0; in_ovr = 0;
      qi_lamp = 0; m_restart = 0;
    end else begin
      bit gone, drop, evt, gest, openm;
      gone  = since_zc >= LOSS;
      drop  = !zc_pulse && since_zc == LOSS - 1;
      evt   = zc_pulse && since_zc >= GAP_MIN && !gone;
      gest  = evt && first_evt >= 0;
      openm = !(mode_sel == 2'b01 || mode_sel == 2'b10);
      m_restart = drop;
      if (gone || drop) first_evt = -1;
      else if (evt) first_evt = gest ? -1 : 0;
      else if (first_evt >= 0) first_evt = (first_evt + 1 >= GWIN) ? -1 : first_evt + 1;
      if (gone || drop || !openm) begin
        in_qi = 0; in_ovr = 0; qi_lamp = 0;
      end else begin
        if (in_qi) begin
          if (motion_trig) begin qi_lamp = QIPUL; qi_quiet = 0; end
          else begin
            if (qi_lamp > 0) qi_lamp--;
            qi_quiet++;
            if (qi_quiet >= QIIDLE) begin in_qi = 0; qi_lamp = 0; end
          end
        end else if (gest && boot < QIWIN) begin
          in_qi = 1; qi_quiet = 0; qi_lamp = 0;
        end
        if (gest && !in_qi && boot >= WARM) begin in_ovr = !in_ovr; ovr_age = 0; end
        else if (in_ovr) begin ovr_age++; if (ovr_age >= OVRON) in_ovr = 0; end
      end
      if (gone || drop) boot = 0; else if (boot < WARM) boot++;
      since_zc = zc_pulse ? 0 : (since_zc < LOSS ? since_zc + 1 : LOSS);
    end
  end

  always @(negedge clk) if (rst_n) begin
    int es;
    string tag;
    es = m_state();
    tag = es == 0 ? "R1" : es == 1 ? "R6" : es == 2 ? "R8" : es == 3 ? "R9" : "R3";
    chk({tag, " model state"}, op_state, es);
    chk({tag, " model lamp"}, lamp_on, (es == 3) || (es == 1 && qi_lamp > 0));
    chk("R2 model trig", trig_out, motion_trig && es == 2);
    chk("R10 model restart", restart, m_restart);
  end

  always @(posedge clk) begin
    #2;
    if (ac_on && zc_phase == 0) zc_pulse = 1; else zc_pulse = 0;
    zc_phase = (zc_phase == 2) ? 0 : zc_phase + 1;
  end

  task automatic cyc(int n); repeat (n) @(posedge clk); #1; endtask
  task automatic gap(int n); ac_on = 0; cyc(n); ac_on = 1; endtask
  task automatic gesture(); gap(15); cyc(10); gap(15); cyc(6); endtask
  task automatic motion(); motion_trig = 1; cyc(1); motion_trig = 0; endtask
  task automatic at_neg(); @(negedge clk); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    cyc(5); rst_n = 1; cyc(2);
    at_neg(); chk("R1 reset state warm-up", op_state, 0);
    chk("R1 reset lamp off", lamp_on, 0);
    cyc(10); motion_trig = 1; at_neg();
    chk("R2 motion ignored in warm-up", trig_out, 0);
    cyc(1); motion_trig = 0;
    gesture(); at_neg();
    chk("R5 early gesture enters quick-install", op_state, 1);
    cyc(1); motion(); cyc(3); at_neg();
    chk("R6 quick-install lamp pulse on", lamp_on, 1);
    cyc(12); at_neg();
    chk("R6 quick-install lamp pulse ended", lamp_on, 0);
    cyc(90); at_neg();
    chk("R7 idle exit returns to warm-up", op_state, 0);
    cyc(260); at_neg();
    chk("R1 warm-up complete automatic", op_state, 2);
    motion_trig = 1; at_neg();
    chk("R2 motion forwarded in automatic", trig_out, 1);
    cyc(1); motion_trig = 0;
    gesture(); at_neg();
    chk("R8 gesture forces on", op_state, 3);
    chk("R8 forced lamp on", lamp_on, 1);
    gesture(); at_neg();
    chk("R8 gesture back to automatic", op_state, 2);
    gesture(); cyc(280); at_neg();
    chk("R9 override still on before hold ends", op_state, 3);
    cyc(30); at_neg();
    chk("R9 override expired to automatic", op_state, 2);
    gap(15); cyc(100); at_neg();
    chk("R4 single gap no effect", op_state, 2);
    gap(15); cyc(60); gap(15); cyc(10); at_neg();
    chk("R4 spaced gaps no effect", op_state, 2);
    gap(4); cyc(4); gap(4); cyc(10); at_neg();
    chk("R4 short gaps not events", op_state, 2);
    mode_sel = 2'b01; cyc(2); at_neg();
    chk("R3 strap high state", op_state, 3);
    chk("R3 strap high lamp", lamp_on, 1);
    mode_sel = 2'b10; cyc(2); at_neg();
    chk("R3 strap low state", op_state, 4);
    chk("R3 strap low lamp", lamp_on, 0);
    mode_sel = 2'b11; cyc(2); at_neg();
    chk("R3 strap 11 automatic", op_state, 2);
    mode_sel = 2'b00; cyc(2);
    begin
      int pulses = 0;
      ac_on = 0;
      for (int i = 0; i < 75; i++) begin at_neg(); if (restart) pulses++; end
      chk("R10 one restart pulse", pulses, 1);
      chk("R10 warm-up during loss", op_state, 0);
    end
    cyc(1); ac_on = 1; cyc(150);
    gesture(); at_neg();
    chk("R8 gesture during late warm-up ignored", op_state, 0);
    cyc(170); at_neg();
    chk("R10 restart warm-up still running", op_state, 0);
    cyc(50); at_neg();
    chk("R10 restart warm-up complete", op_state, 2);
    cyc(5);
    summary();
  end
endmodule